// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is the two-wire serial slave that fronts a small on-chip configuration register file. It runs from a fast system clock, at least 16 times the bus clock, and oversamples the SCL and SDA pads. Each line passes through a two-stage synchroniser and a three-sample majority-free glitch filter. The block then finds START, repeated START and STOP conditions. It answers to a 7-bit address. The upper four bits of that address are the fixed code 1011. The lower three bits come from register 0 of the file itself, so software can move the device on the bus by writing that register.

A write transfer carries a pointer byte followed by any number of data bytes. The data bytes land at consecutive register locations. A read transfer returns bytes from the current pointer until the master declines one. A busy input from a nonvolatile-write engine makes the slave refuse transfers while that engine is working. The SDA output is an open-drain pull-down enable. Clock stretching is not used.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The first byte after a START or repeated START is compared as {4'b1011, A[2:0], rw}, where rw is bit 0 and A[2:0] are bits [2:0] of register 0. On a mismatch the slave never pulls SDA low and ignores the bus until the next START.
- R2: After a matching address byte with busy_i low, and after every accepted write byte, sda_oe_o is 1 for the whole high phase of the ninth SCL pulse. It is released after that pulse's falling edge, unless read data follows.
- R3: A matching address byte or a write data byte received while busy_i is 1 is answered with NACK (sda_oe_o stays 0). The data byte is not stored and the transfer is dropped. Normal answers resume once busy_i is 0.
- R4: In a write transfer the first data byte loads the pointer from its bits [2:0]. Each later byte is stored at the pointer, and the pointer then increments modulo the register count (7 wraps to 0).
- R5: In a read transfer (rw=1) the slave drives the register at the pointer MSB-first. It starts on the SCL falling edge that ends the address ACK. The pointer increments after each byte the master ACKs, and the next register follows at once.
- R6: A master NACK (SDA high on the ninth pulse) ends a read. The slave keeps SDA released and does not increment the pointer.
- R7: A repeated START aborts the current transfer and opens a new address phase without a STOP. The pointer is kept, so a pointer write followed by a read returns that register.
- R8: A STOP returns the slave to idle with sda_oe_o = 0. Bytes clocked afterwards without a START get no ACK.
- R9: sda_oe_o changes only while the filtered SCL is low, except when a START or STOP forces it to release.
- R10: A pulse on SCL or SDA shorter than three system clocks is filtered out and does not disturb bit counting.
- R11: After reset sda_oe_o = 0, every register reads 0, and the device answers at address bits 000.
- R12: Transfers work at both 100 kHz and 400 kHz SCL with the 50 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level, the wired-AND bus value |
| busy_i | input | 1 | Nonvolatile write in progress; the slave refuses transfers |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A wrong state in the transfer engine shows up on SDA within one SCL period. The possible symptoms are:
- a missing or extra ACK on the ninth pulse;
- a read bit that differs from the register model;
- the slave driving SDA during a master data bit.

A wrong pointer or a lost write stays hidden until the next read of that location, so the bench reads back after every kind of write: plain, wrapped, refused while busy and address-changing. A bit counter pushed out of step by a glitch moves the ACK by one pulse, and the very same address byte exposes it.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam logic [3:0] DEV_ID = 4'b1011;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   samp_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      samp_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      samp_q <= {samp_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      // only a full run of equal samples moves the output
      if (&samp_q)       filt_q <= 1'b1;
      else if (~|samp_q) filt_q <= 1'b0;
    end
  end

  assign line_o = filt_q;

  assert_min_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |=> $stable(line_o));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

  assert_edge_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |=> !scl_fall_o);
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DW       = 8,
  localparam int unsigned PTR_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o,
  output logic [2:0]       dev_addr_o
);
  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && waddr_i == PTR_W'(g))     regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o    = regs_q[raddr_i];
  assign dev_addr_o = regs_q[0][2:0];
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic busy_i,
  output logic sda_oe_o
);
  localparam int unsigned PTR_W = $clog2(NUM_REGS);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [1:0] raw_lines, flt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[l]),
      .line_o (flt_lines[l])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  i2c_bus_events i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  slv_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  sh_q, tx_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               rw_q, have_ptr_q, mack_q, oe_q;

  logic               rf_we;
  logic [BYTE_W-1:0]  rf_rdata;
  logic [2:0]         dev_addr;
  logic               byte_end, addr_hit;

  assign byte_end = scl_fall && (cnt_q == FULL);
  assign addr_hit = (sh_q[7:4] == DEV_ID) && (sh_q[3:1] == dev_addr);
  assign rf_we    = (state_q == ST_RX) && byte_end && !busy_i && have_ptr_q;

  i2c_cfg_regfile #(.NUM_REGS(NUM_REGS), .DW(BYTE_W)) i_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (rf_we),
    .waddr_i    (ptr_q),
    .wdata_i    (sh_q),
    .raddr_i    (ptr_q),
    .rdata_o    (rf_rdata),
    .dev_addr_o (dev_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      have_ptr_q <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit && !busy_i) begin
                oe_q       <= 1'b1;
                rw_q       <= sh_q[0];
                have_ptr_q <= 1'b0;
                state_q    <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (busy_i) begin
              state_q <= ST_IDLE;
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              if (!have_ptr_q) begin
                ptr_q      <= sh_q[PTR_W-1:0];
                have_ptr_q <= 1'b1;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_q    <= rf_rdata << 1;
              oe_q    <= ~rf_rdata[BYTE_W-1];
              cnt_q   <= CNT_W'(1);
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == FULL) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              oe_q  <= ~tx_q[BYTE_W-1];
              tx_q  <= tx_q << 1;
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
            if (!sda_f) ptr_q <= ptr_q + 1'b1;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rf_rdata << 1;
              oe_q    <= ~rf_rdata[BYTE_W-1];
              cnt_q   <= CNT_W'(1);
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
        end
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_ev || stop_ev)) |-> !scl_f);

  assert_busy_nack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ADDR || state_q == ST_RX) && byte_end && busy_i && !start_ev && !stop_ev)
      |=> (state_q == ST_IDLE) && !sda_oe_o);

  assert_addr_miss_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && byte_end && !addr_hit && !start_ev && !stop_ev)
      |=> (state_q == ST_IDLE) && !sda_oe_o);

  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev && !start_ev) |=> (state_q == ST_IDLE) && !sda_oe_o);

  assert_ack_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && scl_f) |-> sda_oe_o);
endmodule

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_slave i_i2c_cfg_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .busy_i   (busy),
    .sda_oe_o (sda_oe)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int hp = 62;
  bit done = 1'b0;
  logic [7:0] mdl_regs [8];
  int mdl_ptr = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] adr(input bit rw);
    return {4'hB, mdl_regs[0][2:0], rw};
  endfunction

  function automatic bit aok(input logic [7:0] b);
    return (b[7:4] == 4'hB) && (b[3:1] == mdl_regs[0][2:0]) && !busy;
  endfunction

  // one SCL pulse; compare every clock of the high phase
  task automatic clk_bit(input bit msda, input bit chk_line, input bit exp_v,
                         input string req, input string what, input bit glitch);
    bit ok;
    logic act, act_v;
    ok = 1'b1;
    act_v = exp_v;
    tick(hp / 2);
    sda_m = msda;
    tick(hp - hp / 2);
    scl_m = 1'b1;
    for (int i = 0; i < hp; i++) begin
      @(negedge clk);
      if (glitch && i == hp / 2) begin
        scl_m = 1'b0;
        tick(2);
        scl_m = 1'b1;
      end
      act = chk_line ? sda_line : sda_oe;
      if (act !== exp_v && ok) begin
        ok = 1'b0;
        act_v = act;
      end
    end
    scl_m = 1'b0;
    check(ok, req, what, int'(act_v), int'(exp_v));
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input string req, input bit glitch);
    for (int i = 7; i >= 0; i--)
      clk_bit(b[i], 1'b0, 1'b0, "R9", "oe during master bit", glitch && i == 4);
    clk_bit(1'b1, 1'b0, exp_ack, req, "ack slot", 1'b0);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit ack, input string req);
    for (int i = 7; i >= 0; i--)
      clk_bit(1'b1, 1'b1, exp[i], req, "read bit", 1'b0);
    clk_bit(~ack, 1'b0, 1'b0, "R6", "oe in master ack slot", 1'b0);
  endtask

  task automatic start_c();
    sda_m = 1'b1;
    tick(hp / 2);
    scl_m = 1'b1;
    tick(hp / 2);
    sda_m = 1'b0;
    tick(hp / 2);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    tick(hp / 2);
    sda_m = 1'b0;
    tick(hp / 2);
    scl_m = 1'b1;
    tick(hp / 2);
    sda_m = 1'b1;
    tick(hp);
  endtask

  task automatic wr(input int p, input int n, input logic [7:0] d0,
                    input logic [7:0] d1, input string req);
    logic [7:0] d;
    start_c();
    send_byte(adr(1'b0), aok(adr(1'b0)), "R2", 1'b0);
    send_byte(8'(p), 1'b1, req, 1'b0);
    mdl_ptr = p % 8;
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : d1;
      send_byte(d, 1'b1, req, 1'b0);
      mdl_regs[mdl_ptr] = d;
      mdl_ptr = (mdl_ptr + 1) % 8;
    end
    stop_c();
  endtask

  task automatic rd_loop(input int n, input string req);
    bit last;
    for (int k = 0; k < n; k++) begin
      last = (k == n - 1);
      recv_byte(mdl_regs[mdl_ptr], ~last, req);
      if (!last) mdl_ptr = (mdl_ptr + 1) % 8;
    end
  endtask

  task automatic ptr_read(input int p, input int n, input string req);
    start_c();
    send_byte(adr(1'b0), aok(adr(1'b0)), "R7", 1'b0);
    send_byte(8'(p), 1'b1, "R7", 1'b0);
    mdl_ptr = p;
    start_c();
    send_byte(adr(1'b1), aok(adr(1'b1)), "R7", 1'b0);
    rd_loop(n, req);
    stop_c();
  endtask

  task automatic rd_cur(input int n, input string req);
    start_c();
    send_byte(adr(1'b1), aok(adr(1'b1)), "R5", 1'b0);
    rd_loop(n, req);
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl_regs[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(20);
    check(sda_oe == 1'b0, "R11", "oe after reset", int'(sda_oe), 0);

    // R11: reset contents at default address 000
    ptr_read(1, 2, "R11");

    // R1: wrong identifier gets no ACK
    start_c();
    send_byte(8'hA0, 1'b0, "R1", 1'b0);
    stop_c();

    // R4 / R2: plain write, then R5 R6 R7 read back
    wr(2, 2, 8'hA5, 8'h3C, "R4");
    ptr_read(2, 2, "R5");
    // R6: NACKed byte did not move the pointer -> reg3 again
    rd_cur(1, "R6");

    // R3: busy refuses the address
    busy = 1'b1;
    start_c();
    send_byte(adr(1'b0), aok(adr(1'b0)), "R3", 1'b0);
    stop_c();
    busy = 1'b0;
    // R3: busy rising before a data byte refuses and drops it
    start_c();
    send_byte(adr(1'b0), 1'b1, "R3", 1'b0);
    send_byte(8'h05, 1'b1, "R3", 1'b0);
    mdl_ptr = 5;
    busy = 1'b1;
    send_byte(8'h77, 1'b0, "R3", 1'b0);
    stop_c();
    busy = 1'b0;
    ptr_read(5, 1, "R3");

    // R1: register 0 moves the address to 101
    wr(0, 1, 8'h05, 8'h00, "R1");
    start_c();
    send_byte(8'hB0, aok(8'hB0), "R1", 1'b0);
    stop_c();
    ptr_read(0, 1, "R1");

    // R4: pointer wrap 7 -> 0
    wr(7, 2, 8'h11, 8'h05, "R4");
    ptr_read(7, 2, "R4");

    // R10: short SCL glitch inside the address byte
    start_c();
    send_byte(adr(1'b0), 1'b1, "R10", 1'b1);
    send_byte(8'h03, 1'b1, "R10", 1'b0);
    stop_c();
    mdl_ptr = 3;
    rd_cur(1, "R10");

    // R8: bytes after STOP without START get no ACK
    start_c();
    send_byte(adr(1'b0), 1'b1, "R8", 1'b0);
    stop_c();
    check(sda_oe == 1'b0, "R8", "oe after stop", int'(sda_oe), 0);
    send_byte(adr(1'b0), 1'b0, "R8", 1'b0);
    stop_c();

    // R12: 100 kHz bus
    hp = 250;
    wr(6, 1, 8'h6C, 8'h00, "R12");
    ptr_read(6, 1, "R12");
    hp = 62;
    ptr_read(6, 1, "R12");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule